// File: doc/BRIEF.md
# Folded Cache Line Data Store

This block holds the data words of a single-way cache. It is built from two 32-bit synchronous RAM banks instead of one 64-bit RAM. Words of a line are split by word-index parity: even-indexed words sit in the even bank and odd-indexed words in the odd bank. A full-width read returns a doubleword-aligned word pair in one access. A single-word read enables only the bank that holds the addressed word, so the other bank draws no read power. Tag lookup, hit/miss decisions and the memory-side bus protocol belong to the surrounding cache.

A line holds eight words, so it refills as four pair beats over four or more cycles. The refill port has no ready signal and accepts a beat on every cycle that `fill_valid` is high. The read side has two streams. A request stream (`rd_valid`/`rd_ready`) carries set, word index and size. A response stream (`rsp_valid`/`rsp_ready`) carries the data one cycle later. The response stream applies back-pressure: while a response is stalled, the request side deasserts `rd_ready` and the response data stays frozen. The per-bank enable outputs show RAM activity cycle by cycle, for power accounting.

Top module: `fold_line_store`

## Requirements
- R1: A full-width read (`rd_wide`=1) of set s and word w returns word {w[2:1],0} of line s in `rsp_data[31:0]` and word {w[2:1],1} in `rsp_data[63:32]`.
- R2: A single-word read (`rd_wide`=0) returns the addressed word in `rsp_data[31:0]` with `rsp_data[63:32]` zero. `rsp_valid` is high in the cycle after the request is accepted.
- R3: In a cycle where a single-word read is accepted, only the enable of the bank selected by w[0] is high (0 = even bank, 1 = odd bank). An accepted full-width read raises both enables. With no accepted read, both read enables are low.
- R4: Refill beats are counted from reset, modulo four. Beat k writes `fill_data[31:0]` to word 2k and `fill_data[63:32]` to word 2k+1 of `fill_set`. `ram_wr_en` is high in exactly the cycles where `fill_valid` is high.
- R5: `fill_done` is a one-cycle pulse in the cycle after the fourth beat of a line is accepted. Idle cycles between beats do not reset the beat count.
- R6: A read accepted in the same cycle as a refill beat to the same row returns the data held before that write.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rd_ready` is low, no request is accepted, and `rsp_valid` and `rsp_data` hold their values.
- R8: After reset, `rsp_valid` and `fill_done` are low, `rd_ready` is high, and the beat count is zero.
- R9: A full-width read ignores w[0]: words 2j+0 and 2j+1 select the same pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request can be accepted |
| rd_wide | input | 1 | 1 = word-pair read, 0 = single word |
| rd_set | input | SET_BITS | Set index of the read |
| rd_word | input | 3 | Word index within the line |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 64 | Read data |
| fill_valid | input | 1 | Refill beat present this cycle |
| fill_set | input | SET_BITS | Set being refilled |
| fill_data | input | 64 | Word pair, even word in the low half |
| fill_done | output | 1 | Pulse after the last beat of a line |
| ram_rd_en_even | output | 1 | Read enable of the even bank |
| ram_rd_en_odd | output | 1 | Read enable of the odd bank |
| ram_wr_en | output | 1 | Write enable of both banks |

## Verification
Corrupted stored state, or a wrong beat counter, shows up as wrong `rsp_data` on the next read of that word. The beat counter also moves the `fill_done` pulse by one or more beats. A bank-select fault shows up on the enable pins in the same cycle as the request, and as swapped or wrong halves one cycle later. A response register that fails to hold under stall is seen in the first stalled cycle, through `rsp_valid`, `rsp_data` or `rd_ready`. A behavioural model of the word array, beat count and response slot is compared with the outputs on every clock.

// File: rtl/fold_pkg.sv
package fold_pkg;
  typedef enum logic {
    SZ_WORD = 1'b0,
    SZ_PAIR = 1'b1
  } rd_size_e;

  localparam int BANKS = 2;
endpackage

// File: rtl/fold_bank_ram.sv
module fold_bank_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read sees the array before this edge's write (read-before-write)
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end
endmodule

// File: rtl/fold_rd_ctrl.sv
module fold_rd_ctrl
  import fold_pkg::*;
#(
  parameter int SET_BITS = 4,
  parameter int WIDX_W   = 3,
  localparam int ROW_W   = SET_BITS + WIDX_W - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_valid,
  input  rd_size_e            rd_size,
  input  logic [SET_BITS-1:0] rd_set,
  input  logic [WIDX_W-1:0]   rd_word,
  input  logic                rsp_ready,
  output logic                rd_ready,
  output logic                en_even,
  output logic                en_odd,
  output logic [ROW_W-1:0]    row,
  output logic                rsp_valid,
  output rd_size_e            size_q,
  output logic                odd_q
);
  logic fire;

  assign rd_ready = !rsp_valid || rsp_ready;
  assign fire     = rd_valid && rd_ready;
  assign en_even  = fire && (rd_size == SZ_PAIR || !rd_word[0]);
  assign en_odd   = fire && (rd_size == SZ_PAIR ||  rd_word[0]);
  assign row      = {rd_set, rd_word[WIDX_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      size_q    <= SZ_WORD;
      odd_q     <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      size_q    <= rd_size;
      odd_q     <= rd_word[0];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R3
  narrow_one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_size == SZ_WORD) |-> $countones({en_even, en_odd}) == 1);

  // R2
  rsp_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid);

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(size_q) && $stable(odd_q)));
endmodule

// File: rtl/fold_fill_seq.sv
module fold_fill_seq #(
  parameter int SET_BITS = 4,
  parameter int PAIRS    = 4,
  localparam int BEAT_W  = $clog2(PAIRS),
  localparam int ROW_W   = SET_BITS + BEAT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fill_valid,
  input  logic [SET_BITS-1:0] fill_set,
  output logic                wr_en,
  output logic [ROW_W-1:0]    wr_row,
  output logic                fill_done
);
  logic [BEAT_W-1:0] beat_q;
  logic              last;

  assign last   = (beat_q == BEAT_W'(PAIRS - 1));
  assign wr_en  = fill_valid;
  assign wr_row = {fill_set, beat_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q    <= '0;
      fill_done <= 1'b0;
    end else begin
      fill_done <= fill_valid && last;
      if (fill_valid) beat_q <= last ? '0 : beat_q + 1'b1;
    end
  end

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_done);

  // R5
  done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> ($past(fill_valid) && beat_q == '0));
endmodule

// File: rtl/fold_line_store.sv
module fold_line_store
  import fold_pkg::*;
#(
  parameter int SET_BITS   = 4,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_valid,
  output logic                           rd_ready,
  input  logic                           rd_wide,
  input  logic [SET_BITS-1:0]            rd_set,
  input  logic [$clog2(LINE_WORDS)-1:0]  rd_word,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic [2*WORD_W-1:0]            rsp_data,
  input  logic                           fill_valid,
  input  logic [SET_BITS-1:0]            fill_set,
  input  logic [2*WORD_W-1:0]            fill_data,
  output logic                           fill_done,
  output logic                           ram_rd_en_even,
  output logic                           ram_rd_en_odd,
  output logic                           ram_wr_en
);
  localparam int WIDX_W = $clog2(LINE_WORDS);
  localparam int PAIRS  = LINE_WORDS / 2;
  localparam int ROW_W  = SET_BITS + WIDX_W - 1;

  logic [ROW_W-1:0]  rd_row;
  logic [ROW_W-1:0]  wr_row;
  logic              en_even;
  logic              en_odd;
  rd_size_e          size_q;
  logic              odd_q;
  logic [WORD_W-1:0] bank_q [BANKS];

  fold_rd_ctrl #(
    .SET_BITS (SET_BITS),
    .WIDX_W   (WIDX_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_size   (rd_size_e'(rd_wide)),
    .rd_set    (rd_set),
    .rd_word   (rd_word),
    .rsp_ready (rsp_ready),
    .rd_ready  (rd_ready),
    .en_even   (en_even),
    .en_odd    (en_odd),
    .row       (rd_row),
    .rsp_valid (rsp_valid),
    .size_q    (size_q),
    .odd_q     (odd_q)
  );

  fold_fill_seq #(
    .SET_BITS (SET_BITS),
    .PAIRS    (PAIRS)
  ) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_valid (fill_valid),
    .fill_set   (fill_set),
    .wr_en      (ram_wr_en),
    .wr_row     (wr_row),
    .fill_done  (fill_done)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    fold_bank_ram #(
      .AW (ROW_W),
      .DW (WORD_W)
    ) u_ram (
      .clk     (clk),
      .rd_en   ((b == 0) ? en_even : en_odd),
      .rd_addr (rd_row),
      .rd_data (bank_q[b]),
      .wr_en   (ram_wr_en),
      .wr_addr (wr_row),
      .wr_data (fill_data[b*WORD_W +: WORD_W])
    );
  end

  assign ram_rd_en_even = en_even;
  assign ram_rd_en_odd  = en_odd;

  always_comb begin
    if (size_q == SZ_PAIR) rsp_data = {bank_q[1], bank_q[0]};
    else                   rsp_data = {{WORD_W{1'b0}}, odd_q ? bank_q[1] : bank_q[0]};
  end

  // R7
  rsp_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> $stable(rsp_data));

  // R3
  idle_banks_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rd_ready) |-> !(ram_rd_en_even || ram_rd_en_odd));
endmodule

// File: tb/fold_line_store_tb.sv
module fold_line_store_tb;
  localparam int SB = 4;
  localparam int NS = 1 << SB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_valid, rd_wide, rsp_ready, fill_valid;
  logic [SB-1:0] rd_set, fill_set;
  logic [2:0]    rd_word;
  logic [63:0]   fill_data;
  logic          rd_ready, rsp_valid, fill_done;
  logic [63:0]   rsp_data;
  logic          ram_rd_en_even, ram_rd_en_odd, ram_wr_en;

  always #5 clk = ~clk;

  fold_line_store u_dut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_wide(rd_wide), .rd_set(rd_set), .rd_word(rd_word),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_data(fill_data),
    .fill_done(fill_done), .ram_rd_en_even(ram_rd_en_even),
    .ram_rd_en_odd(ram_rd_en_odd), .ram_wr_en(ram_wr_en)
  );

  int          total = 0;
  int          bad   = 0;
  logic [31:0] mem [NS*8];
  logic        exp_v;
  logic [63:0] exp_d;
  logic        exp_done;
  int          beat;
  string       dtag;
  bit          finished = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: combinational checks, model step at the edge, registered checks
  task automatic cycle();
    logic fire;
    logic [63:0] d;
    int base;
    #1;
    fire = rd_valid && (!exp_v || rsp_ready);
    chk("R7 rd_ready", 64'(rd_ready), 64'(!exp_v || rsp_ready));
    chk("R3 en_even", 64'(ram_rd_en_even), 64'(fire && (rd_wide || !rd_word[0])));
    chk("R3 en_odd", 64'(ram_rd_en_odd), 64'(fire && (rd_wide || rd_word[0])));
    chk("R4 wr_en", 64'(ram_wr_en), 64'(fill_valid));
    @(posedge clk);
    d = '0;
    if (fire) begin
      base = int'(rd_set) * 8;
      if (rd_wide) d = {mem[base + 2*int'(rd_word[2:1]) + 1], mem[base + 2*int'(rd_word[2:1])]};
      else         d = {32'h0, mem[base + int'(rd_word)]};
    end
    exp_done = fill_valid && beat == 3;
    if (fill_valid) begin
      mem[int'(fill_set)*8 + 2*beat]     = fill_data[31:0];
      mem[int'(fill_set)*8 + 2*beat + 1] = fill_data[63:32];
      beat = (beat + 1) % 4;
    end
    if (fire) begin
      exp_v = 1'b1;
      exp_d = d;
    end else if (rsp_ready) exp_v = 1'b0;
    @(negedge clk);
    chk("R2/R7 rsp_valid", 64'(rsp_valid), 64'(exp_v));
    if (exp_v) chk(dtag, rsp_data, exp_d);
    chk("R5 fill_done", 64'(fill_done), 64'(exp_done));
  endtask

  task automatic idle_inputs();
    rd_valid = 0; rd_wide = 0; rd_set = '0; rd_word = '0;
    rsp_ready = 1; fill_valid = 0; fill_set = '0; fill_data = '0;
  endtask

  task automatic rd(input logic wide, input int s, input int w, input string tag);
    idle_inputs();
    dtag = tag;
    rd_valid = 1; rd_wide = wide; rd_set = SB'(s); rd_word = 3'(w);
    cycle();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    exp_v = 0; exp_d = '0; exp_done = 0; beat = 0; dtag = "R1 data";
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset state
    chk("R8 rsp_valid", 64'(rsp_valid), 64'h0);
    chk("R8 fill_done", 64'(fill_done), 64'h0);
    chk("R8 rd_ready", 64'(rd_ready), 64'h1);

    // R4 R5 refill every set, with a gap inside set 3's line
    for (int s = 0; s < NS; s++) begin
      for (int k = 0; k < 4; k++) begin
        if (s == 3 && k == 2) begin idle_inputs(); cycle(); cycle(); end
        idle_inputs();
        fill_valid = 1; fill_set = SB'(s);
        fill_data = {8'(s), 8'(2*k+1), 16'hb0dd, 8'(s), 8'(2*k), 16'hea0e};
        cycle();
      end
    end

    // R1 pair reads, R9 word[0] ignored
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < 8; w++) rd(1'b1, s, w, (w % 2 == 1) ? "R9 pair data" : "R1 pair data");
    // R2 R3 single-word reads
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < 8; w++) rd(1'b0, s, w, "R2 word data");

    // R7 stall with requests pending
    rd(1'b1, 2, 4, "R1 pair data");
    for (int i = 0; i < 4; i++) begin
      idle_inputs(); dtag = "R7 held data";
      rsp_ready = 0; rd_valid = 1; rd_wide = 0; rd_set = 4'd9; rd_word = 3'd3;
      cycle();
    end
    rd(1'b0, 9, 3, "R2 word data");

    // R6 same-row read during refill of set 5
    for (int k = 0; k < 4; k++) begin
      idle_inputs(); dtag = "R6 old data";
      fill_valid = 1; fill_set = 4'd5; fill_data = {32'hc0de0000 | 32'(k), 32'hfeed0000 | 32'(k)};
      rd_valid = 1; rd_wide = 1; rd_set = 4'd5; rd_word = 3'(2*k);
      cycle();
    end
    rd(1'b1, 5, 6, "R6 new data");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      idle_inputs(); dtag = "R1/R2 mixed data";
      rd_valid = 1'($urandom); rd_wide = 1'($urandom);
      rd_set = SB'($urandom); rd_word = 3'($urandom);
      rsp_ready = ($urandom % 4) != 0;
      fill_valid = ($urandom % 3) == 0; fill_set = SB'($urandom);
      fill_data = {$urandom, $urandom};
      cycle();
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule